// File: doc/BRIEF.md
# Polar Code Encoder with Frozen-Bit Insertion

This block turns a short message into a polar codeword of length n = 2^m. Each accepted message is spread over an n-bit source vector. A parameter bitmask marks the information positions in that vector, and every position the mask leaves clear is a frozen position that carries logic 0. The source vector then goes through an m-stage XOR butterfly network. The network computes the product, over GF(2), of the vector and the m-th Kronecker power of the 2x2 kernel with rows [1 0] and [1 1].

The default is an (8, 4) code, so m = 3 and the network has three butterfly stages. The input has a valid/ready handshake, and the block takes a new message on every cycle outside reset. The codeword is registered and comes out together with a valid flag one clock after the message is taken. Choosing the frozen set is done elsewhere and reaches the block only through the mask parameter.

Top module: `polar_encoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `cw_valid` is 0 and `cw_data` is all zeros.
- R2: `cw_valid` is 1 exactly in the cycle after a message is accepted (`msg_valid` and `msg_ready` both high at a rising edge), and 0 after any cycle that accepts no message.
- R3: Codeword bit j is the XOR of every source bit u_i whose index i has all the set bits of j (i AND j equals j). This is u multiplied by the Kronecker power of [1 0; 1 1].
- R4: Message bit r (bit 0 is the least significant) goes to the source position of the r-th set bit of `INFO_MASK`, counting from index 0 upward. With the default mask 8'hE8, message bits 0..3 land at positions 3, 5, 6 and 7.
- R5: Source positions whose mask bit is 0 carry 0 whatever the message is, so the all-zero message encodes to the all-zero codeword.
- R6: `msg_ready` is 1 on every cycle outside reset, so one message can be accepted on each consecutive cycle with no bubbles.
- R7: After a cycle that accepts no message, `cw_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message present on `msg_data` |
| msg_ready | output | 1 | Block can take a message this cycle |
| msg_data | input | K | Information bits, bit 0 first in position order |
| cw_valid | output | 1 | Codeword on `cw_data` is new this cycle |
| cw_data | output | N | Registered codeword, bit j is position j |

## Verification
The in-line properties assume a fixed, legal mask with exactly K set bits. They also assume that `msg_valid` is a clean 0 or 1 on every sampled edge once reset has dropped, because the valid-timing and hold checks key on that handshake. The bench drives every input only at falling edges. It keeps `msg_valid` defined from time zero and uses the default mask. Its stimulus covers all 16 messages back to back, single-bit messages that expose each placement position, an idle gap, and a seeded random mix of valid and idle cycles.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

    localparam int unsigned DEF_STAGES = 3;
    localparam int unsigned DEF_INFO   = 4;
    localparam int unsigned MAX_LEN    = 64;

    // Number of set bits of mask strictly below index pos
    function automatic int unsigned mask_rank(input logic [MAX_LEN-1:0] mask,
                                              input int unsigned pos);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned i = 0; i < MAX_LEN; i++) begin
            if (i < pos && mask[i]) cnt++;
        end
        return cnt;
    endfunction

    // Whether butterfly stage s treats position j as the upper (combining) node
    function automatic bit is_upper(input int unsigned j, input int unsigned s);
        return ((j >> s) & 1) == 0;
    endfunction

endpackage

// File: rtl/polar_info_place.sv
module polar_info_place
    import polar_enc_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned K = 4,
    parameter logic [N-1:0] INFO_MASK = 8'hE8
) (
    input  logic [K-1:0] msg,
    output logic [N-1:0] src
);
    localparam logic [MAX_LEN-1:0] WIDE_MASK = MAX_LEN'(INFO_MASK);

    for (genvar p = 0; p < N; p++) begin : g_pos
        if (INFO_MASK[p]) begin : g_info
            localparam int unsigned RANK = mask_rank(WIDE_MASK, p);
            assign src[p] = msg[RANK];
        end else begin : g_frozen
            assign src[p] = 1'b0;
        end
    end
endmodule

// File: rtl/polar_butterfly.sv
module polar_butterfly
    import polar_enc_pkg::*;
#(
    parameter int unsigned M = 3,
    localparam int unsigned N = 1 << M
) (
    input  logic [N-1:0] vec_in,
    output logic [N-1:0] vec_out
);
    logic [N-1:0] lvl [M+1];

    assign lvl[0] = vec_in;

    for (genvar s = 0; s < M; s++) begin : g_stage
        localparam int unsigned SPAN = 1 << s;
        for (genvar j = 0; j < N; j++) begin : g_node
            if (is_upper(j, s)) begin : g_up
                assign lvl[s+1][j] = lvl[s][j] ^ lvl[s][j+SPAN];
            end else begin : g_low
                assign lvl[s+1][j] = lvl[s][j];
            end
        end
    end

    assign vec_out = lvl[M];
endmodule

// File: rtl/polar_encoder.sv
module polar_encoder
    import polar_enc_pkg::*;
#(
    parameter int unsigned M = DEF_STAGES,
    parameter int unsigned K = DEF_INFO,
    localparam int unsigned N = 1 << M,
    parameter logic [N-1:0] INFO_MASK = 8'hE8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         msg_valid,
    output logic         msg_ready,
    input  logic [K-1:0] msg_data,
    output logic         cw_valid,
    output logic [N-1:0] cw_data
);
    logic [N-1:0] src_vec;
    logic [N-1:0] xform;
    logic         take;

    assign msg_ready = ~rst;
    assign take      = msg_valid & msg_ready;

    polar_info_place #(.N(N), .K(K), .INFO_MASK(INFO_MASK)) place_i (
        .msg (msg_data),
        .src (src_vec)
    );

    polar_butterfly #(.M(M)) bfly_i (
        .vec_in  (src_vec),
        .vec_out (xform)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_valid <= 1'b0;
            cw_data  <= '0;
        end else begin
            cw_valid <= take;
            if (take) cw_data <= xform;
        end
    end

    // Placement: frozen positions stay zero, and no message bit is lost
    assert_frozen_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (src_vec & ~INFO_MASK) == '0);
    assert_bits_kept_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(src_vec) == $countones(msg_data));

    // Transform: column 0 of the Kronecker power is all ones, last column has only the last row
    assert_col0_parity_R3: assert property (@(posedge clk) disable iff (rst)
        xform[0] == ^src_vec);
    assert_last_col_R3: assert property (@(posedge clk) disable iff (rst)
        xform[N-1] == src_vec[N-1]);

    // Output timing and hold
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> cw_valid);
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> !cw_valid);
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cw_data));
endmodule

// File: tb/polar_encoder_tb_top.sv
`timescale 1ns/1ps
module polar_encoder_tb_top;
    localparam int unsigned M = 3;
    localparam int unsigned N = 1 << M;
    localparam int unsigned K = 4;
    localparam logic [N-1:0] MASK = 8'hE8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [K-1:0] msg_data = '0;
    logic         cw_valid;
    logic [N-1:0] cw_data;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [N-1:0] last_cw = '0;

    always #2.5 clk = ~clk;

    polar_encoder #(.M(M), .K(K), .INFO_MASK(MASK)) dut_i (
        .clk, .rst, .msg_valid, .msg_ready, .msg_data, .cw_valid, .cw_data
    );

    function automatic logic [N-1:0] ref_place(input logic [K-1:0] m);
        logic [N-1:0] u;
        int unsigned r;
        u = '0; r = 0;
        for (int p = 0; p < N; p++) begin
            if (MASK[p]) begin
                u[p] = m[r];
                r++;
            end
        end
        return u;
    endfunction

    // Entry (i,j) of the Kronecker power: product of kernel entries per bit
    function automatic bit gen_entry(input int i, input int j);
        bit kern [2][2];
        bit g;
        kern[0][0] = 1; kern[0][1] = 0; kern[1][0] = 1; kern[1][1] = 1;
        g = 1;
        for (int b = 0; b < M; b++) g = g & kern[(i >> b) & 1][(j >> b) & 1];
        return g;
    endfunction

    function automatic logic [N-1:0] ref_encode(input logic [N-1:0] u);
        logic [N-1:0] x;
        x = '0;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                x[j] = x[j] ^ (u[i] & gen_entry(i, j));
        return x;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at falling edge, sample 1 ns after the next rising edge
    task automatic step(input logic v, input logic [K-1:0] m, input string req);
        logic [N-1:0] exp_cw;
        @(negedge clk);
        msg_valid = v;
        msg_data  = m;
        check("R6", N'(msg_ready), N'(1'b1));
        @(posedge clk);
        #1;
        exp_cw = v ? ref_encode(ref_place(m)) : last_cw;
        check("R2", N'(cw_valid), N'(v));
        check(v ? req : "R7", cw_data, exp_cw);
        last_cw = exp_cw;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] row;
        int unsigned seed;
        seed = 32'd12345;
        repeat (3) @(posedge clk);
        #1;
        check("R1", N'(cw_valid), '0);
        check("R1", cw_data, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", N'(cw_valid), '0);
        check("R1", cw_data, '0);

        // R5: all-zero message gives all-zero codeword
        step(1'b1, 4'h0, "R5");
        // R3, R6: every message back to back
        for (int m = 0; m < 16; m++) step(1'b1, 4'(m), "R3");
        // R4: single-bit messages expose the row of the mask position
        for (int r = 0; r < K; r++) begin
            int pos;
            pos = -1;
            for (int p = 0, c = 0; p < N; p++) if (MASK[p]) begin
                if (c == r) pos = p;
                c++;
            end
            step(1'b1, 4'(1 << r), "R4");
            for (int j = 0; j < N; j++) row[j] = gen_entry(pos, j);
            check("R4", cw_data, row);
        end
        // R2, R7: idle gap keeps data and drops valid
        step(1'b0, 4'hF, "R7");
        step(1'b0, 4'h5, "R7");
        step(1'b1, 4'hA, "R3");
        // Seeded random mix
        for (int t = 0; t < 300; t++) begin
            logic v;
            logic [K-1:0] m;
            v = ($urandom(seed) % 4) != 0;
            seed = seed + 32'd7919;
            m = K'($urandom(seed));
            seed = seed + 32'd104729;
            step(v, m, "R3");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule